// File: doc/BRIEF.md
# PWM Fault and Current-Limit Output Guard

This block sits between a PWM generator and the output pins of one PWM pair. It watches two asynchronous protection inputs, a fault input and a current-limit input, and when either is qualified it forces the high and low PWM outputs to a programmed 2-bit safe value. Each input has its own polarity select and its own response mode: cycle-by-cycle, where the forced state ends at the next primary period-start pulse once the input has gone inactive, or latched, where the forced state holds until software clears it.

The current-limit input can be blanked for a programmable time after a rising edge, a falling edge, or both edges of the raw high-side PWM. This hides switching spikes. A current-limit condition that is still present when the blanking window closes takes effect at that point. In independent mode the two inputs split their work: current limit acts on the high output only, and fault acts on the low output only. Sticky status flags record every event whether or not interrupts are enabled. Interrupt requests are one-cycle pulses, gated by their enables.

Top module: `pwm_fault_guard`

## Requirements
- R1: With neither condition held, the outputs copy `pwm_h_in`/`pwm_l_in` one clock later. Reset drives both outputs and all flags and requests to 0.
- R2: Each protection input passes through a two-flop synchronizer. Its active level is the matching polarity bit: 1 means active high, 0 means active low.
- R3: Mode code 2'b01 is cycle-by-cycle. An active input forces the outputs, and the forced state is kept until a `period_start` pulse arrives while the input is inactive. This works for any spacing of the pulses, including center-aligned timing.
- R4: Mode code 2'b00 is latched. Only the inactive-to-active transition sets the state; the opposite transition does nothing. The state is kept through period starts. `sw_clr` ends it only while the input is inactive.
- R5: Mode codes 2'b10 and 2'b11 disable the input, so it has no effect on the outputs or the flags.
- R6: A rising edge of `pwm_h_in` starts a blanking window when `blank_rise_en` is set, and a falling edge starts one when `blank_fall_en` is set. The window lasts `blank_cfg[9:3]` × `BLANK_STEP` clocks; bits 2:0 are ignored. A current-limit pulse that lies inside the window is ignored.
- R7: A current-limit condition that is still active when the window closes acts at that moment.
- R8: Outside independent mode, a fault drives {h,l} to `flt_ovr` (bit 1 = high, bit 0 = low), and a current limit drives them to `cl_ovr`. Fault wins when both are present.
- R9: With `indep_mode` set, the current limit forces only the high output (to `cl_ovr[1]`), and the fault forces only the low output (to `flt_ovr[0]`).
- R10: `flt_stat`/`cl_stat` set whenever the state is entered, regardless of the interrupt enables. `sw_clr` clears a flag only while its input is inactive.
- R11: `flt_irq`/`cl_irq` pulse for one cycle on entry to the state, and only when the matching enable is set.
- R12: Both outputs change to the forced value in the same clock. The complementary output never shows a mixed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwm_h_in | input | 1 | Raw high-side PWM |
| pwm_l_in | input | 1 | Raw low-side PWM |
| period_start | input | 1 | Primary period boundary pulse |
| flt_in | input | 1 | Asynchronous fault input |
| cl_in | input | 1 | Asynchronous current-limit input |
| flt_pol | input | 1 | Fault active level |
| cl_pol | input | 1 | Current-limit active level |
| flt_mode | input | 2 | Fault mode: 00 latched, 01 cycle, 1x off |
| cl_mode | input | 2 | Current-limit mode, same codes |
| indep_mode | input | 1 | Split fault/limit per output |
| flt_ovr | input | 2 | Forced {h,l} on fault |
| cl_ovr | input | 2 | Forced {h,l} on current limit |
| blank_rise_en | input | 1 | Blank after rising PWM edge |
| blank_fall_en | input | 1 | Blank after falling PWM edge |
| blank_cfg | input | BLANK_W+3 | Blanking time, steps in bits [top:3] |
| flt_ien | input | 1 | Fault interrupt enable |
| cl_ien | input | 1 | Current-limit interrupt enable |
| sw_clr | input | 1 | Software clear strobe |
| pwm_h_out | output | 1 | Guarded high-side PWM |
| pwm_l_out | output | 1 | Guarded low-side PWM |
| flt_stat | output | 1 | Sticky fault flag |
| cl_stat | output | 1 | Sticky current-limit flag |
| flt_irq | output | 1 | Fault interrupt pulse |
| cl_irq | output | 1 | Current-limit interrupt pulse |

## Verification
The bench sweeps every override value under both polarities. A polarity inversion would show as forcing while idle, and a swapped override bit would show as the wrong pin forced. Latched mode is driven with the opposite edge while the input was already active: a design that latches on any edge would force there. It also applies a clear while the input is held: a design that ignores the input level would release the outputs. Blanking is probed just inside and just after a window with nonzero low bits. A design that uses the low bits, or that drops a limit which persists past the window, misses one of those samples. The same probe is repeated for falling-edge-only arming. Independent mode, interrupt gating, and irregular period spacing with a toggling complementary pair complete the set, and a mixed 11 output state is counted as a failure.

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
  parameter int BLANK_W    = 7,
  parameter int BLANK_STEP = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwm_h_in,
  input  logic               pwm_l_in,
  input  logic               period_start,
  input  logic               flt_in,
  input  logic               cl_in,
  input  logic               flt_pol,
  input  logic               cl_pol,
  input  logic [1:0]         flt_mode,
  input  logic [1:0]         cl_mode,
  input  logic               indep_mode,
  input  logic [1:0]         flt_ovr,
  input  logic [1:0]         cl_ovr,
  input  logic               blank_rise_en,
  input  logic               blank_fall_en,
  input  logic [BLANK_W+2:0] blank_cfg,
  input  logic               flt_ien,
  input  logic               cl_ien,
  input  logic               sw_clr,
  output logic               pwm_h_out,
  output logic               pwm_l_out,
  output logic               flt_stat,
  output logic               cl_stat,
  output logic               flt_irq,
  output logic               cl_irq
);
  localparam int CFG_W = BLANK_W + 3;
  localparam int CNT_W = BLANK_W + $clog2(BLANK_STEP + 1) + 1;

  logic [1:0] flt_sy, cl_sy;
  logic       h_d, flt_act_d, cl_act_d;
  logic       flt_st, cl_st;
  logic [CNT_W-1:0] blank_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_sy <= '0;
      cl_sy  <= '0;
    end else begin
      flt_sy <= {flt_sy[0], flt_in};
      cl_sy  <= {cl_sy[0], cl_in};
    end

  wire flt_act    = flt_sy[1] ~^ flt_pol;
  wire cl_raw_act = cl_sy[1] ~^ cl_pol;

  wire rise_e = pwm_h_in & ~h_d;
  wire fall_e = ~pwm_h_in & h_d;
  wire [CNT_W-1:0] blank_len = CNT_W'(blank_cfg[CFG_W-1:3]) * CNT_W'(BLANK_STEP);
  wire blanking = (blank_cnt != '0);
  wire cl_act   = cl_raw_act & ~blanking;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      h_d       <= 1'b0;
      blank_cnt <= '0;
    end else begin
      h_d <= pwm_h_in;
      if ((rise_e && blank_rise_en) || (fall_e && blank_fall_en))
        blank_cnt <= blank_len;
      else if (blanking)
        blank_cnt <= blank_cnt - 1'b1;
    end

  function automatic logic next_st(input logic [1:0] mode, input logic st,
                                   input logic act, input logic act_d,
                                   input logic ps, input logic clr);
    case (mode)
      2'b00:   next_st = (act & ~act_d) | (st & ~(clr & ~act));
      2'b01:   next_st = act | (st & ~ps);
      default: next_st = 1'b0;
    endcase
  endfunction

  wire flt_nx = next_st(flt_mode, flt_st, flt_act, flt_act_d, period_start, sw_clr);
  wire cl_nx  = next_st(cl_mode, cl_st, cl_act, cl_act_d, period_start, sw_clr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_act_d <= 1'b0;
      cl_act_d  <= 1'b0;
      flt_st    <= 1'b0;
      cl_st     <= 1'b0;
      flt_stat  <= 1'b0;
      cl_stat   <= 1'b0;
      flt_irq   <= 1'b0;
      cl_irq    <= 1'b0;
    end else begin
      flt_act_d <= flt_act;
      cl_act_d  <= cl_act;
      flt_st    <= flt_nx;
      cl_st     <= cl_nx;
      flt_stat  <= flt_nx | (flt_stat & ~(sw_clr & ~flt_act));
      cl_stat   <= cl_nx | (cl_stat & ~(sw_clr & ~cl_raw_act));
      flt_irq   <= flt_ien & flt_nx & ~flt_st;
      cl_irq    <= cl_ien & cl_nx & ~cl_st;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pwm_h_out <= 1'b0;
      pwm_l_out <= 1'b0;
    end else if (indep_mode) begin
      pwm_h_out <= cl_st  ? cl_ovr[1]  : pwm_h_in;
      pwm_l_out <= flt_st ? flt_ovr[0] : pwm_l_in;
    end else if (flt_st) begin
      {pwm_h_out, pwm_l_out} <= flt_ovr;
    end else if (cl_st) begin
      {pwm_h_out, pwm_l_out} <= cl_ovr;
    end else begin
      {pwm_h_out, pwm_l_out} <= {pwm_h_in, pwm_l_in};
    end
endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flt_st,
  input logic       cl_st,
  input logic       blanking,
  input logic [1:0] flt_mode,
  input logic       pwm_h_in,
  input logic       pwm_l_in,
  input logic       pwm_h_out,
  input logic       pwm_l_out,
  input logic       period_start,
  input logic       sw_clr,
  input logic       indep_mode,
  input logic [1:0] cl_ovr,
  input logic       flt_irq,
  input logic       flt_ien,
  input logic       flt_stat
);
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_st && !cl_st) |=> (pwm_h_out == $past(pwm_h_in) && pwm_l_out == $past(pwm_l_in))); // R1
  AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_mode == 2'b01 && flt_st && !period_start) |=> flt_st); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_mode == 2'b00 && flt_st && !sw_clr) |=> flt_st); // R4
  AST_BLANK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (blanking && !cl_st) |=> !cl_st); // R6
  AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_st) |-> flt_stat); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    flt_irq |-> $past(flt_ien)); // R11
  AST_PAIR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!indep_mode && cl_st && !flt_st) |=> ({pwm_h_out, pwm_l_out} == $past(cl_ovr))); // R12
endmodule

bind pwm_fault_guard pwm_fault_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flt_st(flt_st), .cl_st(cl_st), .blanking(blanking),
  .flt_mode(flt_mode), .pwm_h_in(pwm_h_in), .pwm_l_in(pwm_l_in),
  .pwm_h_out(pwm_h_out), .pwm_l_out(pwm_l_out), .period_start(period_start),
  .sw_clr(sw_clr), .indep_mode(indep_mode), .cl_ovr(cl_ovr), .flt_irq(flt_irq),
  .flt_ien(flt_ien), .flt_stat(flt_stat)
);

// File: tb/pwm_fault_guard_tb_top.sv
`timescale 1ns/1ps
module pwm_fault_guard_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic h_in = 0, l_in = 0, ps = 0, flt_in = 0, cl_in = 0;
  logic flt_pol = 1, cl_pol = 1, indep = 0, rise_en = 0, fall_en = 0;
  logic [1:0] flt_mode = 2'b10, cl_mode = 2'b10, flt_ovr = 0, cl_ovr = 0;
  logic [9:0] blank_cfg = 0;
  logic flt_ien = 0, cl_ien = 0, sw_clr = 0;
  logic h_out, l_out, flt_stat, cl_stat, flt_irq, cl_irq;
  int n_chk = 0, n_bad = 0, irq_cnt = 0, mixed_cnt = 0;
  logic mon_mixed = 0;
  logic done = 0;

  always #2 clk = ~clk;

  pwm_fault_guard dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_h_in(h_in), .pwm_l_in(l_in), .period_start(ps),
    .flt_in(flt_in), .cl_in(cl_in), .flt_pol(flt_pol), .cl_pol(cl_pol),
    .flt_mode(flt_mode), .cl_mode(cl_mode), .indep_mode(indep), .flt_ovr(flt_ovr),
    .cl_ovr(cl_ovr), .blank_rise_en(rise_en), .blank_fall_en(fall_en),
    .blank_cfg(blank_cfg), .flt_ien(flt_ien), .cl_ien(cl_ien), .sw_clr(sw_clr),
    .pwm_h_out(h_out), .pwm_l_out(l_out), .flt_stat(flt_stat), .cl_stat(cl_stat),
    .flt_irq(flt_irq), .cl_irq(cl_irq));

  always @(negedge clk) begin
    if (flt_irq || cl_irq) irq_cnt++;
    if (mon_mixed && h_out && l_out) mixed_cnt++;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_ps();
    ps = 1; step(1); ps = 0;
  endtask

  task automatic pulse_clr();
    sw_clr = 1; step(1); sw_clr = 0;
  endtask

  function automatic int outs();
    return {h_out, l_out};
  endfunction

  initial begin
    step(3);
    chk("R1 reset outs", outs(), 0);
    chk("R1 reset flags", {flt_stat, cl_stat, flt_irq, cl_irq}, 0);
    rst_n = 1;
    step(2);

    for (int v = 0; v < 4; v++) begin
      {h_in, l_in} = v[1:0];
      step(1);
      chk("R1 pass", outs(), v);
    end

    {h_in, l_in} = 2'b10;
    flt_in = 1; step(8);
    chk("R5 disabled out", outs(), 2);
    chk("R5 disabled flag", flt_stat, 0);
    flt_in = 0; step(4);

    for (int p = 0; p < 2; p++) begin
      for (int ov = 0; ov < 4; ov++) begin
        flt_mode = 2'b10; flt_pol = p[0]; flt_in = ~p[0]; flt_ovr = ov[1:0];
        step(4);
        flt_mode = 2'b01; step(4);
        chk("R2 idle", outs(), 2);
        flt_in = p[0]; step(6);
        chk("R8 forced", outs(), ov);
        chk("R10 flag no ien", flt_stat, 1);
        flt_in = ~p[0]; step(6);
        chk("R3 hold to period", outs(), ov);
        pulse_ps(); step(3);
        chk("R3 cleared", outs(), 2);
        pulse_clr(); step(1);
        chk("R10 flag clr", flt_stat, 0);
      end
    end
    chk("R11 no irq", irq_cnt, 0);

    flt_mode = 2'b10; flt_pol = 1; flt_in = 0; flt_ovr = 0; step(4);
    flt_mode = 2'b00; step(2);
    flt_in = 1; step(6);
    chk("R4 latched", outs(), 0);
    flt_in = 0; step(6);
    pulse_ps(); step(3);
    chk("R4 hold past period", outs(), 0);
    flt_in = 1; step(4);
    pulse_clr(); step(4);
    chk("R4 clr while active", outs(), 0);
    flt_in = 0; step(4);
    chk("R4 still held", outs(), 0);
    pulse_clr(); step(3);
    chk("R4 cleared", outs(), 2);
    flt_mode = 2'b10; flt_pol = 0; flt_in = 0; step(4);
    flt_mode = 2'b00; step(4);
    chk("R4 no edge", outs(), 2);
    flt_in = 1; step(6);
    chk("R4 opposite edge", outs(), 2);
    flt_in = 0; step(6);
    chk("R4 matching edge", outs(), 0);
    flt_in = 1; step(3); pulse_clr(); step(3);
    chk("R4 clr after", outs(), 2);
    flt_mode = 2'b10; flt_pol = 1; flt_in = 0; step(4);

    flt_ien = 1; flt_mode = 2'b01; irq_cnt = 0;
    for (int k = 0; k < 2; k++) begin
      flt_in = 1; step(6); flt_in = 0; step(4); pulse_ps(); step(3);
    end
    chk("R11 irq pulses", irq_cnt, 2);
    flt_ien = 0; flt_mode = 2'b10; pulse_clr(); step(2);

    cl_mode = 2'b01; cl_ovr = 0; rise_en = 1; blank_cfg = {7'd10, 3'b111};
    {h_in, l_in} = 2'b01; step(4);
    {h_in, l_in} = 2'b10; cl_in = 1; step(5);
    chk("R6 blanked", outs(), 2);
    cl_in = 0; step(20);
    chk("R6 pulse ignored out", outs(), 2);
    chk("R6 pulse ignored flag", cl_stat, 0);
    {h_in, l_in} = 2'b01; step(3);
    {h_in, l_in} = 2'b10; cl_in = 1; step(17);
    chk("R7 inside window", outs(), 2);
    step(9);
    chk("R7 after window", outs(), 0);
    cl_in = 0; step(3); pulse_ps(); step(3);
    chk("R7 released", outs(), 2);

    rise_en = 0; fall_en = 1;
    {h_in, l_in} = 2'b01; step(30);
    {h_in, l_in} = 2'b10; cl_in = 1; step(8);
    chk("R6 rise not armed", outs(), 0);
    cl_in = 0; step(3); pulse_ps(); step(3);
    {h_in, l_in} = 2'b01; cl_in = 1; step(8);
    chk("R6 fall blanked", outs(), 1);
    step(20);
    chk("R7 fall then act", outs(), 0);
    cl_in = 0; step(3); pulse_ps(); step(30);
    fall_en = 0; pulse_clr(); step(2);

    indep = 1; flt_mode = 2'b01; flt_ovr = 2'b01; cl_ovr = 2'b01;
    {h_in, l_in} = 2'b10;
    cl_in = 1; step(8);
    chk("R9 limit high only", outs(), 0);
    cl_in = 0; flt_in = 1; step(3); pulse_ps(); step(4);
    chk("R9 fault low only", outs(), 3);
    flt_in = 0; step(3); pulse_ps(); step(3);
    indep = 0; cl_ovr = 2'b10;
    flt_in = 1; cl_in = 1; step(8);
    chk("R8 fault wins", outs(), 1);
    flt_in = 0; cl_in = 0; step(3); pulse_ps(); step(3);
    chk("R8 released", outs(), 2);

    flt_mode = 2'b10; cl_ovr = 0; mon_mixed = 1;
    for (int c = 0; c < 120; c++) begin
      {h_in, l_in} = ((c / 3) % 2 == 0) ? 2'b10 : 2'b01;
      ps = (c % 17 == 0) || (c % 17 == 7);
      cl_in = (c >= 30 && c < 36);
      if (c == 40) chk("R3 center forced", outs(), 0);
      step(1);
    end
    ps = 0; step(2);
    chk("R3 center released", (outs() == 1 || outs() == 2) ? 1 : 0, 1);
    chk("R12 no mixed state", mixed_cnt, 0);
    mon_mixed = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule